// File: doc/BRIEF.md
# Stack Bounds Protection Checker

This block watches the memory accesses of a processor pipeline and flags any load or store whose base register is the stack pointer (register index 1) when its effective address leaves a window set by two limit registers. An address below the floor register is reported as a stack overflow. An address above the ceiling register is reported as a stack underflow. The report is a violation pulse with a two-bit cause code, in the same cycle as the access. The pulse is only raised while the machine status exception-enable bit is set. With that bit clear, the access simply proceeds.

The two limit registers sit behind a special-register port that selects a register by a 16-bit identifier. The floor uses identifier 0x0800 and the ceiling uses 0x0802. After reset the window covers the whole address space, so no access is flagged. Two build-time parameters can remove the feature: a stack-protection switch that must equal 1, and a memory-management level that must equal 0. When the feature is removed, the block never flags an access, ignores writes and reads back zero.

Top module: `stack_guard`

## Requirements
- R1: Only a cycle with `acc_valid` high, `acc_mem` high and `acc_base` equal to 1 can raise `viol_pulse`. Any other base index, a non-memory instruction or an idle cycle never does.
- R2: With checking armed, an address strictly greater than the ceiling raises `viol_pulse` with `viol_cause` = 2'b10 (underflow). An address equal to the ceiling is not flagged.
- R3: With checking armed, an address strictly less than the floor raises `viol_pulse` with `viol_cause` = 2'b01 (overflow). An address equal to the floor is not flagged.
- R4: If an address is both below the floor and above the ceiling (floor set above ceiling), the cause is 2'b01: overflow has priority.
- R5: While `exc_en` is low, `viol_pulse` stays low and `viol_cause` is 2'b00 for every access.
- R6: After reset the floor reads 0x00000000 and the ceiling reads 0xFFFFFFFF. With `sr_rd` high, identifier 0x0800 returns the floor, 0x0802 returns the ceiling and any other identifier returns zero.
- R7: A write with `sr_wr` high takes effect at the next clock edge. An access or a read in the same cycle as the write sees the old limit value.
- R8: A write to an identifier other than 0x0800 or 0x0802 changes neither limit register.
- R9: When the stack-protection parameter is not 1, or the memory-management level is above 0, `viol_pulse` is never raised, writes are ignored and `sr_rdata` is always zero.
- R10: `viol_pulse` is combinational and lasts only while the offending access is presented. When it is low, `viol_cause` is 2'b00. When `sr_rd` is low, `sr_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An instruction is presented this cycle |
| acc_mem | input | 1 | The instruction is a load or a store |
| acc_base | input | 5 | Base register index of the access |
| acc_addr | input | 32 | Effective address of the access |
| exc_en | input | 1 | Exception-enable bit from machine status |
| sr_wr | input | 1 | Special-register write strobe |
| sr_rd | input | 1 | Special-register read strobe |
| sr_id | input | 16 | Special-register identifier |
| sr_wdata | input | 32 | Special-register write data |
| viol_pulse | output | 1 | Stack protection violation for the current access |
| viol_cause | output | 2 | 01 overflow, 10 underflow, 00 none |
| sr_rdata | output | 32 | Special-register read data |

## Verification
Two functions can fall in the same cycle: a limit-register write, and a checked stack access or a readback of the same register. The bench provokes this by writing the ceiling, presenting an access above the old ceiling and reading the ceiling, all in one cycle. It judges the outcome against the pre-write value, then repeats the access one cycle later and expects the new limit to apply. A second copy of the block is built with a memory-management level above zero and receives the same stimulus, so every cycle also checks that this copy stays silent.

// File: rtl/stack_guard_pkg.sv
package stack_guard_pkg;

  localparam int unsigned SRID_BITS = 16;
  localparam logic [SRID_BITS-1:0] SRID_FLOOR = 16'h0800;
  localparam logic [SRID_BITS-1:0] SRID_CEIL  = 16'h0802;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_OVER  = 2'b01,
    CAUSE_UNDER = 2'b10
  } viol_cause_e;

  // Overflow wins when the window is inverted and both sides trip.
  function automatic viol_cause_e pick_cause(input logic below, input logic above);
    if (below)      return CAUSE_OVER;
    else if (above) return CAUSE_UNDER;
    else            return CAUSE_NONE;
  endfunction

endpackage

// File: rtl/stack_access_qual.sv
module stack_access_qual #(
  parameter int unsigned REG_IDX_W = 5,
  parameter int unsigned SP_INDEX  = 1
) (
  input  logic                 acc_valid,
  input  logic                 acc_mem,
  input  logic [REG_IDX_W-1:0] acc_base,
  input  logic                 exc_en,
  output logic                 stack_hit,
  output logic                 armed
);

  function automatic logic is_stack_base(input logic [REG_IDX_W-1:0] idx);
    return idx == REG_IDX_W'(SP_INDEX);
  endfunction

  always_comb begin
    stack_hit = acc_valid && acc_mem && is_stack_base(acc_base);
    armed     = stack_hit && exc_en;
  end

endmodule

// File: rtl/stack_window_cmp.sv
module stack_window_cmp #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] floor_lim,
  input  logic [ADDR_W-1:0] ceil_lim,
  output logic              below,
  output logic              above
);

  function automatic logic under_floor(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] f);
    return a < f;
  endfunction

  function automatic logic over_ceil(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] c);
    return a > c;
  endfunction

  always_comb begin
    below = under_floor(addr, floor_lim);
    above = over_ceil(addr, ceil_lim);
  end

endmodule

// File: rtl/stack_limit_file.sv
module stack_limit_file
  import stack_guard_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned SRID_W  = 16,
  parameter bit          PROT_ON = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sr_wr,
  input  logic              sr_rd,
  input  logic [SRID_W-1:0] sr_id,
  input  logic [ADDR_W-1:0] sr_wdata,
  output logic [ADDR_W-1:0] floor_lim,
  output logic [ADDR_W-1:0] ceil_lim,
  output logic [ADDR_W-1:0] sr_rdata
);

  logic sel_floor;
  logic sel_ceil;

  always_comb begin
    sel_floor = sr_id == SRID_W'(SRID_FLOOR);
    sel_ceil  = sr_id == SRID_W'(SRID_CEIL);
  end

  generate
    if (PROT_ON) begin : g_regs
      logic [ADDR_W-1:0] floor_q;
      logic [ADDR_W-1:0] ceil_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          floor_q <= '0;
          ceil_q  <= '1;
        end else if (sr_wr) begin
          if (sel_floor) floor_q <= sr_wdata;
          if (sel_ceil)  ceil_q  <= sr_wdata;
        end
      end

      always_comb begin
        floor_lim = floor_q;
        ceil_lim  = ceil_q;
        if (!sr_rd)         sr_rdata = '0;
        else if (sel_floor) sr_rdata = floor_q;
        else if (sel_ceil)  sr_rdata = ceil_q;
        else                sr_rdata = '0;
      end

      // R7
      limit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sr_wr && (sel_floor || sel_ceil)) |=> ($stable(floor_q) && $stable(ceil_q)));

      // R6
      unknown_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_rd && !sel_floor && !sel_ceil) |-> (sr_rdata == '0));
    end else begin : g_none
      always_comb begin
        floor_lim = '0;
        ceil_lim  = '1;
        sr_rdata  = '0;
      end
    end
  endgenerate

endmodule

// File: rtl/stack_guard.sv
module stack_guard
  import stack_guard_pkg::*;
#(
  parameter int unsigned USE_STACK_PROT = 1,
  parameter int unsigned MMU_LEVEL      = 0,
  parameter int unsigned ADDR_W         = 32,
  parameter int unsigned REG_IDX_W      = 5,
  parameter int unsigned SP_INDEX       = 1,
  parameter int unsigned SRID_W         = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_valid,
  input  logic                 acc_mem,
  input  logic [REG_IDX_W-1:0] acc_base,
  input  logic [ADDR_W-1:0]    acc_addr,
  input  logic                 exc_en,
  input  logic                 sr_wr,
  input  logic                 sr_rd,
  input  logic [SRID_W-1:0]    sr_id,
  input  logic [ADDR_W-1:0]    sr_wdata,
  output logic                 viol_pulse,
  output logic [1:0]           viol_cause,
  output logic [ADDR_W-1:0]    sr_rdata
);

  localparam bit PROT_ON = (USE_STACK_PROT == 1) && (MMU_LEVEL == 0);

  logic              stack_hit;
  logic              armed;
  logic              lim_below;
  logic              lim_above;
  logic              out_of_window;
  logic [ADDR_W-1:0] floor_lim;
  logic [ADDR_W-1:0] ceil_lim;

  stack_access_qual #(
    .REG_IDX_W (REG_IDX_W),
    .SP_INDEX  (SP_INDEX)
  ) u_qual (
    .acc_valid (acc_valid),
    .acc_mem   (acc_mem),
    .acc_base  (acc_base),
    .exc_en    (exc_en),
    .stack_hit (stack_hit),
    .armed     (armed)
  );

  stack_limit_file #(
    .ADDR_W  (ADDR_W),
    .SRID_W  (SRID_W),
    .PROT_ON (PROT_ON)
  ) u_limits (
    .clk       (clk),
    .rst_n     (rst_n),
    .sr_wr     (sr_wr),
    .sr_rd     (sr_rd),
    .sr_id     (sr_id),
    .sr_wdata  (sr_wdata),
    .floor_lim (floor_lim),
    .ceil_lim  (ceil_lim),
    .sr_rdata  (sr_rdata)
  );

  stack_window_cmp #(
    .ADDR_W (ADDR_W)
  ) u_cmp (
    .addr      (acc_addr),
    .floor_lim (floor_lim),
    .ceil_lim  (ceil_lim),
    .below     (lim_below),
    .above     (lim_above)
  );

  always_comb begin
    out_of_window = lim_below || lim_above;
    viol_pulse    = PROT_ON && armed && out_of_window;
    viol_cause    = viol_pulse ? pick_cause(lim_below, lim_above) : CAUSE_NONE;
  end

  // R1
  base_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stack_hit |-> !viol_pulse);

  // R5
  exc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_en |-> (!viol_pulse && viol_cause == 2'b00));

  // R10
  cause_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !viol_pulse |-> (viol_cause == 2'b00));

  // R4
  cause_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |-> ($countones(viol_cause) == 1));

  // R4
  over_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_pulse && lim_below) |-> (viol_cause == 2'b01));

endmodule

// File: tb/test_stack_guard.sv
module test_stack_guard;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_mem = 1'b0;
  logic [4:0]  acc_base = '0;
  logic [31:0] acc_addr = '0;
  logic        exc_en = 1'b0;
  logic        sr_wr = 1'b0;
  logic        sr_rd = 1'b0;
  logic [15:0] sr_id = '0;
  logic [31:0] sr_wdata = '0;
  logic        viol_pulse, m_pulse;
  logic [1:0]  viol_cause, m_cause;
  logic [31:0] sr_rdata, m_rdata;

  int checks = 0;
  int errors = 0;

  logic        q_pulse[$];
  logic [1:0]  q_cause[$];
  logic [31:0] q_rdata[$];
  string       q_tag[$];

  logic [31:0] floor_m = 32'h0000_0000;
  logic [31:0] ceil_m  = 32'hFFFF_FFFF;

  always #2.5 clk = ~clk;

  stack_guard i_stack_guard (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_mem(acc_mem),
    .acc_base(acc_base), .acc_addr(acc_addr), .exc_en(exc_en),
    .sr_wr(sr_wr), .sr_rd(sr_rd), .sr_id(sr_id), .sr_wdata(sr_wdata),
    .viol_pulse(viol_pulse), .viol_cause(viol_cause), .sr_rdata(sr_rdata)
  );

  stack_guard #(.MMU_LEVEL(1)) i_stack_guard_mmu (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_mem(acc_mem),
    .acc_base(acc_base), .acc_addr(acc_addr), .exc_en(exc_en),
    .sr_wr(sr_wr), .sr_rd(sr_rd), .sr_id(sr_id), .sr_wdata(sr_wdata),
    .viol_pulse(m_pulse), .viol_cause(m_cause), .sr_rdata(m_rdata)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, expected result pushed to the scoreboard.
  task automatic drive(input logic v, input logic m, input logic [4:0] b, input logic [31:0] a,
                       input logic e, input logic w, input logic r, input logic [15:0] id,
                       input logic [31:0] wd, input string tag);
    logic below, above, fire;
    logic [1:0] cause;
    logic [31:0] rd;
    @(posedge clk);
    #1;
    acc_valid = v; acc_mem = m; acc_base = b; acc_addr = a; exc_en = e;
    sr_wr = w; sr_rd = r; sr_id = id; sr_wdata = wd;
    below = a < floor_m;
    above = a > ceil_m;
    fire  = v && m && (b == 5'd1) && e && (below || above);
    cause = !fire ? 2'b00 : (below ? 2'b01 : 2'b10);
    rd    = !r ? 32'h0 : (id == 16'h0800 ? floor_m : (id == 16'h0802 ? ceil_m : 32'h0));
    q_pulse.push_back(fire);
    q_cause.push_back(cause);
    q_rdata.push_back(rd);
    q_tag.push_back(tag);
    if (w && id == 16'h0800) floor_m = wd;
    if (w && id == 16'h0802) ceil_m = wd;
  endtask

  task automatic acc(input logic [4:0] b, input logic [31:0] a, input logic e, input string tag);
    drive(1'b1, 1'b1, b, a, e, 1'b0, 1'b0, 16'h0, 32'h0, tag);
  endtask

  task automatic wr(input logic [15:0] id, input logic [31:0] d, input string tag);
    drive(1'b0, 1'b0, 5'd0, 32'h0, 1'b1, 1'b1, 1'b0, id, d, tag);
  endtask

  task automatic rd(input logic [15:0] id, input string tag);
    drive(1'b0, 1'b0, 5'd0, 32'h0, 1'b1, 1'b0, 1'b1, id, 32'h0, tag);
  endtask

  // Monitor: pops one expected item per driven cycle, between the edges.
  initial begin
    forever begin
      @(negedge clk);
      if (q_tag.size() != 0) begin
        string t;
        t = q_tag.pop_front();
        check(t, "viol_pulse", 32'(viol_pulse), 32'(q_pulse.pop_front()));
        check(t, "viol_cause", 32'(viol_cause), 32'(q_cause.pop_front()));
        check(t, "sr_rdata", sr_rdata, q_rdata.pop_front());
        check("R9", "disabled viol_pulse", 32'(m_pulse), 32'h0);
        check("R9", "disabled sr_rdata", m_rdata, 32'h0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R6 reset values and readback
    rd(16'h0800, "R6");
    rd(16'h0802, "R6");
    acc(5'd1, 32'h0000_0000, 1'b1, "R6");
    acc(5'd1, 32'hFFFF_FFFF, 1'b1, "R6");
    wr(16'h0800, 32'h0000_1000, "R6");
    wr(16'h0802, 32'h0000_2000, "R6");
    rd(16'h0800, "R6");
    rd(16'h0802, "R6");
    // R1 base and qualifier gating
    acc(5'd1, 32'h0000_3000, 1'b1, "R1");
    acc(5'd2, 32'h0000_3000, 1'b1, "R1");
    acc(5'd0, 32'h0000_0010, 1'b1, "R1");
    drive(1'b0, 1'b1, 5'd1, 32'h3000, 1'b1, 1'b0, 1'b0, 16'h0, 32'h0, "R1");
    drive(1'b1, 1'b0, 5'd1, 32'h3000, 1'b1, 1'b0, 1'b0, 16'h0, 32'h0, "R1");
    // R2 ceiling boundary
    acc(5'd1, 32'h0000_2000, 1'b1, "R2");
    acc(5'd1, 32'h0000_2001, 1'b1, "R2");
    // R3 floor boundary
    acc(5'd1, 32'h0000_1000, 1'b1, "R3");
    acc(5'd1, 32'h0000_0FFF, 1'b1, "R3");
    // R5 exceptions disabled
    acc(5'd1, 32'h0000_3000, 1'b0, "R5");
    acc(5'd1, 32'h0000_0001, 1'b0, "R5");
    // R7 write, access and read in one cycle see the old ceiling
    drive(1'b1, 1'b1, 5'd1, 32'h3000, 1'b1, 1'b1, 1'b1, 16'h0802, 32'h0000_4000, "R7");
    acc(5'd1, 32'h0000_3000, 1'b1, "R7");
    rd(16'h0802, "R7");
    // R8 writes to other identifiers are ignored
    wr(16'h0801, 32'h0000_0000, "R8");
    wr(16'h1000, 32'hFFFF_FFFF, "R8");
    rd(16'h0800, "R8");
    rd(16'h0802, "R8");
    rd(16'h0801, "R8");
    // R4 inverted window: overflow has priority
    wr(16'h0800, 32'h0000_5000, "R4");
    acc(5'd1, 32'h0000_4800, 1'b1, "R4");
    acc(5'd1, 32'h0000_6000, 1'b1, "R4");
    acc(5'd1, 32'h0000_0100, 1'b1, "R4");
    // R10 pulse ends with the access; no read strobe gives zero
    drive(1'b0, 1'b0, 5'd1, 32'h0100, 1'b1, 1'b0, 1'b0, 16'h0800, 32'h0, "R10");
    drive(1'b0, 1'b0, 5'd0, 32'h0, 1'b1, 1'b0, 1'b0, 16'h0802, 32'h0, "R10");
    @(posedge clk);
    #1 sr_wr = 1'b0; sr_rd = 1'b0; acc_valid = 1'b0;
    repeat (3) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule